// File: doc/BRIEF.md
# Calendar Register-File Two-Wire Slave with Supply-Loss Lockout

This block is the two-wire (I2C) slave interface for a 20-byte clock/calendar register bank. It samples the open-drain SCL and SDA lines through a two-flop synchronizer running on a fast system clock. It works out START and STOP conditions from those samples and matches a fixed device address. Bytes are written into, or read out of, the bank through a single pointer that advances by itself after each byte. The timekeeping counters that would normally update the bank are outside this block.

A write transaction carries the pointer value in its first data byte and register data in the bytes after it. A read transaction streams bytes from the pointer onward until the master answers with a NACK. A supply-fail input ends whatever transfer is under way and clears the pointer. While that input is asserted, nothing on the bus is acknowledged or stored.

The controller is one state machine with these states:
- ST_IDLE: waiting for a START.
- ST_ADDR: shifting in the address byte.
- ST_ADDR_ACK: driving the address acknowledge.
- ST_RX: shifting in a write byte.
- ST_RX_ACK: driving the acknowledge for a write byte.
- ST_TX: shifting out a read byte.
- ST_TX_ACK: sampling the master's acknowledge.
- ST_LOCK: supply fail.

Transitions:
- A START goes from any state except ST_LOCK to ST_ADDR.
- A STOP goes to ST_IDLE.
- ST_ADDR goes to ST_ADDR_ACK after the eighth bit if the address matches, and to ST_IDLE otherwise.
- ST_ADDR_ACK goes to ST_RX for a write and to ST_TX for a read.
- ST_RX and ST_RX_ACK alternate, and so do ST_TX and ST_TX_ACK.
- ST_TX_ACK goes to ST_IDLE on a NACK.
- Any state goes to ST_LOCK while supply fail is asserted.
- ST_LOCK goes to ST_IDLE once supply fail is released.

Top module: `i2c_calreg_slave`

## Requirements
- R1: After reset the slave releases SDA (sda_oe = 0), the pointer is 0, and every register reads 00h.
- R2: The slave acknowledges only the address byte D0h (write) or D1h (read). This is the 7-bit address 68h sent MSB first, with the R/W bit in bit 0 and 1 meaning read. With any other address it acknowledges no byte until the next START, and it stores nothing.
- R3: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. After a STOP, bytes clocked in without a new START are not acknowledged.
- R4: In a write, the first data byte loads the pointer; a value of 20 or more loads 0. Each later byte is stored at the pointer, and then the pointer increments. The slave acknowledges every byte.
- R5: In a read, the slave sends the byte at the pointer MSB first and increments the pointer after each byte. It keeps sending while the master acknowledges, and releases SDA after a NACK.
- R6: The pointer wraps from 19 to 0, both when writing and when reading.
- R7: Locations 16 to 18 are reserved. Writes to them are acknowledged but discarded, and reads from them return 00h.
- R8: A repeated START returns the slave to address matching and leaves the pointer unchanged.
- R9: Asserting supply fail releases SDA in the next cycle, aborts the transfer, and sets the pointer to 0.
- R10: While supply fail is asserted, no byte is acknowledged and no register changes.
- R11: The slave starts driving SDA low only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_fail | input | 1 | Supply out of tolerance, synchronous to clk |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions take for granted that the master changes SDA only while SCL is low, except when it forms a START or a STOP. They also assume each SCL level lasts several system clocks, so that the synchronizer and edge logic see every level. The bench drives its bit-banged master at quarter-bit steps of eight system clocks and changes SDA only in the SCL-low quarter. It drives supply fail as a synchronous level, and releases it only after bringing the bus back to idle with a STOP.

// File: rtl/i2c_calreg_pkg.sv
package i2c_calreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_LOCK
    } slv_state_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s    = scl_pipe[STAGES-1];
    assign sda_s    = sda_pipe[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NUM_REGS  = 20,
    parameter int RSV_FIRST = 16,
    parameter int RSV_LAST  = 18,
    parameter int PW        = $clog2(NUM_REGS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);

    logic [7:0] slot [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
        if (i >= RSV_FIRST && i <= RSV_LAST) begin : g_rsv
            assign slot[i] = 8'h00;
        end else begin : g_reg
            logic [7:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 8'h00;
                end else if (we && addr == PW'(i)) begin
                    q <= wdata;
                end
            end
            assign slot[i] = q;
        end
    end

    assign rdata = slot[addr];

endmodule

// File: rtl/i2c_calreg_slave.sv
module i2c_calreg_slave
    import i2c_calreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         NUM_REGS    = 20,
    parameter int         RSV_FIRST   = 16,
    parameter int         RSV_LAST    = 18,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_fail,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);

    localparam int PW   = $clog2(NUM_REGS);
    localparam int BCW  = $clog2(BYTE_BITS + 1);
    localparam logic [PW-1:0] PTR_LAST = PW'(NUM_REGS - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

    slv_state_t     state, state_n;
    logic [7:0]     shreg, shreg_n;
    logic [BCW-1:0] bitcnt, bitcnt_n;
    logic [PW-1:0]  ptr, ptr_n;
    logic           drive, drive_n;
    logic           rw, rw_n;
    logic           ptr_phase, ptr_phase_n;
    logic           mnack, mnack_n;
    logic           reg_we;
    logic [7:0]     rd_data;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    i2c_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .RSV_FIRST (RSV_FIRST),
        .RSV_LAST  (RSV_LAST),
        .PW        (PW)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (ptr),
        .wdata (shreg),
        .rdata (rd_data)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // Next state and datapath decisions
    always_comb begin
        state_n     = state;
        shreg_n     = shreg;
        bitcnt_n    = bitcnt;
        ptr_n       = ptr;
        drive_n     = drive;
        rw_n        = rw;
        ptr_phase_n = ptr_phase;
        mnack_n     = mnack;
        reg_we      = 1'b0;

        if (pwr_fail) begin
            state_n  = ST_LOCK;
            drive_n  = 1'b0;
            ptr_n    = '0;
            bitcnt_n = '0;
        end else if (state == ST_LOCK) begin
            state_n = ST_IDLE;
            drive_n = 1'b0;
        end else if (start_ev) begin
            state_n  = ST_ADDR;
            bitcnt_n = '0;
            drive_n  = 1'b0;
        end else if (stop_ev) begin
            state_n = ST_IDLE;
            drive_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    drive_n = 1'b0;
                end
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg_n  = {shreg[6:0], sda_s};
                        bitcnt_n = bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == BCW'(BYTE_BITS)) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            state_n = ST_ADDR_ACK;
                            drive_n = 1'b1;
                            rw_n    = shreg[0];
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bitcnt_n = '0;
                        if (rw) begin
                            state_n = ST_TX;
                            shreg_n = rd_data;
                            drive_n = ~rd_data[7];
                            ptr_n   = ptr_inc(ptr);
                        end else begin
                            state_n     = ST_RX;
                            drive_n     = 1'b0;
                            ptr_phase_n = 1'b1;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise) begin
                        shreg_n  = {shreg[6:0], sda_s};
                        bitcnt_n = bitcnt + 1'b1;
                    end else if (scl_fall && bitcnt == BCW'(BYTE_BITS)) begin
                        state_n = ST_RX_ACK;
                        drive_n = 1'b1;
                        if (ptr_phase) begin
                            ptr_phase_n = 1'b0;
                            ptr_n = (int'(shreg) < NUM_REGS) ? shreg[PW-1:0] : '0;
                        end else begin
                            reg_we = 1'b1;
                            ptr_n  = ptr_inc(ptr);
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        state_n  = ST_RX;
                        drive_n  = 1'b0;
                        bitcnt_n = '0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bitcnt == BCW'(BYTE_BITS - 1)) begin
                            state_n  = ST_TX_ACK;
                            drive_n  = 1'b0;
                            bitcnt_n = '0;
                        end else begin
                            shreg_n  = {shreg[6:0], 1'b0};
                            drive_n  = ~shreg[6];
                            bitcnt_n = bitcnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mnack_n = sda_s;
                    end else if (scl_fall) begin
                        if (!mnack) begin
                            state_n  = ST_TX;
                            shreg_n  = rd_data;
                            drive_n  = ~rd_data[7];
                            ptr_n    = ptr_inc(ptr);
                            bitcnt_n = '0;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                ST_LOCK: begin
                    state_n = ST_IDLE;
                end
                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // Registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            bitcnt    <= '0;
            ptr       <= '0;
            drive     <= 1'b0;
            rw        <= 1'b0;
            ptr_phase <= 1'b0;
            mnack     <= 1'b1;
        end else begin
            shreg     <= shreg_n;
            bitcnt    <= bitcnt_n;
            ptr       <= ptr_n;
            drive     <= drive_n;
            rw        <= rw_n;
            ptr_phase <= ptr_phase_n;
            mnack     <= mnack_n;
        end
    end

    assign sda_oe = drive;

endmodule

// File: rtl/i2c_calreg_slave_chk.sv
module i2c_calreg_slave_chk #(
    parameter int NUM_REGS = 20,
    parameter int PW       = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_fail,
    input logic          scl_s,
    input logic          sda_oe,
    input logic          reg_we,
    input logic [PW-1:0] ptr
);

    AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);  // R11

    AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ptr) < NUM_REGS);  // R6

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && int'(ptr) == NUM_REGS - 1) |=> ptr == '0);  // R6

    AST_PFAIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> !sda_oe);  // R9

    AST_PFAIL_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> ptr == '0);  // R9

    AST_PFAIL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |-> !reg_we);  // R10

endmodule

bind i2c_calreg_slave i2c_calreg_slave_chk #(
    .NUM_REGS (NUM_REGS),
    .PW       (PW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_fail (pwr_fail),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .reg_we   (reg_we),
    .ptr      (ptr)
);

// File: tb/tb_i2c_calreg_slave.sv
module tb_i2c_calreg_slave;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_line;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int r11_viol = 0;
    logic [7:0] model [20];

    assign sda_line = m_sda & ~sda_oe;

    always #4 clk = ~clk;

    i2c_calreg_slave dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe)
    );

    typedef struct packed {
        logic [7:0] ptr;
        logic [7:0] wdat;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{8'd0,  8'h12, 8'h12},
        '{8'd1,  8'h59, 8'h59},
        '{8'd3,  8'hA5, 8'hA5},
        '{8'd9,  8'h3C, 8'h3C},
        '{8'd15, 8'hF0, 8'hF0},
        '{8'd16, 8'h77, 8'h00},
        '{8'd18, 8'hFF, 8'h00},
        '{8'd19, 8'h81, 8'h81},
        '{8'd12, 8'h5A, 8'h5A}
    };

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run did not finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Observe R11 at the ports: the slave may begin pulling SDA only while SCL is low
    logic oe_q = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_oe && !oe_q && m_scl) r11_viol <= r11_viol + 1;
        oe_q <= sda_oe;
    end

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b0; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic i2c_stop();
        m_sda = 1'b0; qwait();
        m_scl = 1'b1; qwait();
        m_sda = 1'b1; qwait();
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; qwait();
        m_scl = 1'b1; qwait(); qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic get_bit(output logic b);
        m_sda = 1'b1; qwait();
        m_scl = 1'b1; qwait();
        b = sda_line; qwait();
        m_scl = 1'b0; qwait();
    endtask

    task automatic wb(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic rb(output logic [7:0] d, input logic nack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(nack);
    endtask

    task automatic wr1(input logic [7:0] p, input logic [7:0] d, output logic all_ack, output logic any_ack);
        logic a0, a1, a2;
        i2c_start();
        wb(8'hD0, a0); wb(p, a1); wb(d, a2);
        i2c_stop();
        all_ack = a0 & a1 & a2;
        any_ack = a0 | a1 | a2;
    endtask

    task automatic rd1(input logic [7:0] p, output logic [7:0] d);
        logic a;
        i2c_start();
        wb(8'hD0, a); wb(p, a);
        i2c_start();
        wb(8'hD1, a);
        rb(d, 1'b1);
        i2c_stop();
    endtask

    initial begin
        logic all_a, any_a, a;
        logic [7:0] d, d2, d3;

        for (int i = 0; i < 20; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        qwait();

        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda released", {7'd0, sda_oe}, 8'h00);
        i2c_start();
        wb(8'hD1, a);
        check(a, "R2 read address ack", {7'd0, a}, 8'h01);
        rb(d, 1'b0);
        rb(d2, 1'b1);
        i2c_stop();
        check(d == 8'h00, "R1 reg0 after reset", d, 8'h00);
        check(d2 == 8'h00, "R1 reg1 after reset", d2, 8'h00);

        // Vector table: R4 write, R7 reserved, R6 top slot
        for (int v = 0; v < NV; v++) begin
            wr1(VECS[v].ptr, VECS[v].wdat, all_a, any_a);
            check(all_a, "R4 R7 write acked", {7'd0, all_a}, 8'h01);
            rd1(VECS[v].ptr, d);
            check(d == VECS[v].exp, "R4 R7 readback", d, VECS[v].exp);
            model[VECS[v].ptr] = VECS[v].exp;
        end

        // R2: foreign address ignored
        i2c_start();
        wb(8'hA0, a); check(!a, "R2 foreign address nack", {7'd0, a}, 8'h00);
        wb(8'h00, a); check(!a, "R2 foreign pointer nack", {7'd0, a}, 8'h00);
        wb(8'h66, a);
        i2c_stop();
        rd1(8'd0, d);
        check(d == model[0], "R2 no store on foreign address", d, model[0]);

        // R3: no response without START
        i2c_stop();
        wb(8'hD0, a);
        check(!a, "R3 byte after STOP nack", {7'd0, a}, 8'h00);
        i2c_stop();

        // R5: sequential read from 1
        rd1(8'd1, d);
        i2c_start();
        wb(8'hD0, a); wb(8'd1, a);
        i2c_start();
        wb(8'hD1, a);
        rb(d, 1'b0); rb(d2, 1'b0); rb(d3, 1'b1);
        i2c_stop();
        check(d == model[1], "R5 read byte 1", d, model[1]);
        check(d2 == model[2], "R5 read byte 2", d2, model[2]);
        check(d3 == model[3], "R5 read byte 3", d3, model[3]);

        // R6: wrap on write and read
        i2c_start();
        wb(8'hD0, a); wb(8'd19, a); wb(8'hC4, a); wb(8'h4D, a);
        i2c_stop();
        model[19] = 8'hC4; model[0] = 8'h4D;
        i2c_start();
        wb(8'hD0, a); wb(8'd19, a);
        i2c_start();
        wb(8'hD1, a);
        rb(d, 1'b0); rb(d2, 1'b1);
        i2c_stop();
        check(d == 8'hC4, "R6 slot 19", d, 8'hC4);
        check(d2 == 8'h4D, "R6 wrapped to slot 0", d2, 8'h4D);

        // R4: out-of-range pointer loads 0
        wr1(8'd25, 8'h6B, all_a, any_a);
        model[0] = 8'h6B;
        rd1(8'd0, d);
        check(d == 8'h6B, "R4 pointer 25 maps to 0", d, 8'h6B);

        // R8: repeated START keeps pointer
        i2c_start();
        wb(8'hD0, a); wb(8'd15, a);
        i2c_start();
        wb(8'hD1, a);
        check(a, "R8 address ack after repeated START", {7'd0, a}, 8'h01);
        rb(d, 1'b1);
        i2c_stop();
        check(d == model[15], "R8 pointer kept", d, model[15]);

        // R9: abort mid read, pointer cleared
        i2c_start();
        wb(8'hD0, a); wb(8'd15, a);
        i2c_start();
        wb(8'hD1, a);
        get_bit(a); get_bit(a);
        m_sda = 1'b1;
        pwr_fail = 1'b1;
        @(negedge clk); @(negedge clk);
        check(sda_oe == 1'b0, "R9 SDA released on supply fail", {7'd0, sda_oe}, 8'h00);
        i2c_stop();
        // R10: writes ignored while supply fail asserted
        wr1(8'd3, 8'hEE, all_a, any_a);
        check(!any_a, "R10 no ack during supply fail", {7'd0, any_a}, 8'h00);
        pwr_fail = 1'b0;
        qwait();
        i2c_start();
        wb(8'hD1, a);
        rb(d, 1'b1);
        i2c_stop();
        check(d == model[0], "R9 pointer back to 0", d, model[0]);
        rd1(8'd3, d);
        check(d == model[3], "R10 register unchanged", d, model[3]);

        check(r11_viol == 0, "R11 drive began with SCL high", r11_viol[7:0], 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule